// File: doc/BRIEF.md
# Skewed Shift-Register Block Transposer

This block sits between two one-dimensional transform stages and turns a block of N row vectors into N column vectors without any RAM. Each cycle it accepts one N-word row in parallel. Two triangular arrays of shift registers do the reordering. Each array has one lane of every length from 1 to N, so the two hold N²+N words in total. Between the arrays sits a crossbar of N N:1 word multiplexers.

In the first triangle, word k of every row drops into the lane of length k+1. The words of one row therefore reach the crossbar on N different cycles. One select value steers the crossbar. It is generated from the incoming row index and passed down a delay chain, so each multiplexer sees the select of its neighbour one cycle later. The second triangle undoes the skew, and a complete column appears at the output on a single cycle.

Rows keep streaming in while earlier columns drain. Back-to-back blocks therefore sustain one full block every N cycles. Blocks may also be separated by idle gaps of any length.

Top module: `tpose_skew_buffer`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a block has been supplied.
- R2: Each cycle with `in_valid` high delivers one row. Rows are numbered 0 to N-1 in arrival order, and numbering wraps after row N-1. The rows of one block must arrive on N consecutive cycles.
- R3: Output column k carries, in word position r (bits r*W to r*W+W-1), word k of input row r. Input word k likewise occupies bits k*W to k*W+W-1.
- R4: Column 0 of a block is presented exactly N+1 cycles after the cycle in which row 0 of that block was accepted. Column k follows on the cycle N+1+k after that row.
- R5: `out_valid` is high for exactly N consecutive cycles per block, and never at any other time. Back-to-back blocks produce an unbroken run of `out_valid`, which is one block per N cycles.
- R6: An idle gap of any length between blocks, including gaps shorter than the drain time, leaves both the timing of R4 and the content of R3 unchanged for every block.
- R7: The value on `in_words` during cycles with `in_valid` low has no effect on any presented column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Row vector present on `in_words` |
| in_words | input | N*W (128) | Row vector, word k at bits k*W +: W |
| out_valid | output | 1 | Column vector present on `out_words` |
| out_words | output | N*W (128) | Column vector, word r at bits r*W +: W |

## Verification
The hardest case to reach is a new block arriving while the previous one is still draining. In that case the first triangle holds the tail of one block and the head of the next, and the select delay chain carries two different phases at once. The stimulus reaches this state with back-to-back blocks, and with gaps of 1, 3 and 7 cycles, which are shorter than the N+1 cycle drain. Garbage is driven on the data inputs during the gaps. Every column is compared against the transpose and against its predicted cycle.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  localparam int unsigned TP_LANES = 8;
  localparam int unsigned TP_WORD  = 16;

  // Width of a lane/row index for a given lane count (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/tpose_skew_lane.sv
module tpose_skew_lane #(
  parameter int W   = 16,
  parameter int LEN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Stage 0 is the tail, stage LEN-1 the head.
  logic [W-1:0] stg_q [LEN];
  logic [W-1:0] stg_d [LEN];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < LEN; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  // Datapath registers carry no reset.
  always_ff @(posedge clk) begin
    if (en) begin
      for (int i = 0; i < LEN; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign q = stg_q[LEN-1];

  AST_LANE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)) else $error("lane head moved while idle"); // R6

endmodule

// File: rtl/tpose_sel_chain.sv
module tpose_sel_chain #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 row_vld,
  input  logic [SW-1:0]        row_idx,
  output logic [N-1:0]         vld_q,
  output logic [N-1:0][SW-1:0] sel_q
);

  logic [N-1:0]         vld_d;
  logic [N-1:0][SW-1:0] sel_d;

  always_comb begin
    vld_d[0] = row_vld;
    sel_d[0] = row_idx;
    for (int i = 1; i < N; i++) begin
      vld_d[i] = vld_q[i-1];
      sel_d[i] = sel_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      sel_q <= '0;
    end else if (en) begin
      vld_q <= vld_d;
      sel_q <= sel_d;
    end
  end

  // Consecutive rows entering the chain must carry consecutive indices.
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[0] && $past(vld_q[0])) |->
      (32'(sel_q[0]) == (32'($past(sel_q[0])) + 1) % N))
    else $error("row index did not advance"); // R2

endmodule

// File: rtl/tpose_xbar.sv
module tpose_xbar #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int SW = 3
) (
  input  logic [N*W-1:0]  src,
  input  logic [N*SW-1:0] sel,
  output logic [N*W-1:0]  dst
);

  for (genvar m = 0; m < N; m++) begin : g_mux
    logic [SW-1:0] pick;
    assign pick = sel[m*SW +: SW];

    always_comb begin
      dst[m*W +: W] = '0;
      for (int k = 0; k < N; k++) begin
        if (32'(pick) == k) begin
          dst[m*W +: W] = src[k*W +: W];
        end
      end
    end
  end

endmodule

// File: rtl/tpose_skew_buffer.sv
module tpose_skew_buffer
  import tpose_pkg::*;
#(
  parameter int N = TP_LANES,
  parameter int W = TP_WORD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N*W-1:0] in_words,
  output logic         out_valid,
  output logic [N*W-1:0] out_words
);

  localparam int SW = idx_bits(N);
  localparam int PW = $clog2(N + 3) + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // Row index within the current block.
  logic [SW-1:0] row_q, row_d;
  always_comb begin
    row_d = row_q;
    if (in_valid) begin
      row_d = (row_q == SW'(N-1)) ? '0 : row_q + SW'(1);
    end
  end
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) row_q <= '0;
    else         row_q <= row_d;
  end

  // Select delay chain. Stage 0 feeds the multiplexer of the longest lane.
  logic [N-1:0]         ch_vld;
  logic [N-1:0][SW-1:0] ch_sel;
  logic                 out_vld_q;
  logic                 busy;

  assign busy = in_valid | (|ch_vld) | out_vld_q;

  tpose_sel_chain #(.N(N), .SW(SW)) u_chain (
    .clk     (clk),
    .rst_n   (rst_ok),
    .en      (busy),
    .row_vld (in_valid),
    .row_idx (row_q),
    .vld_q   (ch_vld),
    .sel_q   (ch_sel)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)   out_vld_q <= 1'b0;
    else if (busy) out_vld_q <= ch_vld[N-1];
  end

  // First triangle: word k enters the lane of length k+1.
  logic [N*W-1:0] heads_a;
  for (genvar k = 0; k < N; k++) begin : g_tri_a
    tpose_skew_lane #(.W(W), .LEN(k+1)) u_lane (
      .clk   (clk),
      .rst_n (rst_ok),
      .en    (busy),
      .d     (in_words[k*W +: W]),
      .q     (heads_a[k*W +: W])
    );
  end

  // Crossbar: the multiplexer for lane m uses chain stage N-1-m.
  logic [N*SW-1:0] xsel;
  logic [N*W-1:0]  xout;
  for (genvar m = 0; m < N; m++) begin : g_xsel
    assign xsel[m*SW +: SW] = ch_sel[N-1-m];
  end

  tpose_xbar #(.N(N), .W(W), .SW(SW)) u_xbar (
    .src (heads_a),
    .sel (xsel),
    .dst (xout)
  );

  // Second triangle: lane m has length m+1; output word r is lane N-1-r.
  logic [N*W-1:0] heads_b;
  for (genvar m = 0; m < N; m++) begin : g_tri_b
    tpose_skew_lane #(.W(W), .LEN(m+1)) u_lane (
      .clk   (clk),
      .rst_n (rst_ok),
      .en    (busy),
      .d     (xout[m*W +: W]),
      .q     (heads_b[m*W +: W])
    );
  end

  for (genvar r = 0; r < N; r++) begin : g_out
    assign out_words[r*W +: W] = heads_b[(N-1-r)*W +: W];
  end
  assign out_valid = out_vld_q;

  // Check-only counters: rows in flight and column position.
  logic [PW-1:0] pend_q;
  logic [SW-1:0] col_q;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pend_q <= '0;
      col_q  <= '0;
    end else begin
      pend_q <= pend_q + PW'(in_valid) - PW'(out_vld_q);
      if (out_vld_q) col_q <= (col_q == SW'(N-1)) ? '0 : col_q + SW'(1);
    end
  end

  AST_NO_ORPHAN_COL: assert property (@(posedge clk) disable iff (!rst_ok)
    out_vld_q |-> (pend_q != '0)) else $error("column without rows"); // R1

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_ok)
    pend_q <= PW'(N+1)) else $error("rows held beyond latency"); // R4

  AST_COL_RUN: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(out_vld_q) |-> (col_q == '0)) else $error("partial column run"); // R5

endmodule

// File: tb/sim_tpose_skew_buffer.sv
module sim_tpose_skew_buffer;

  localparam int N = 8;
  localparam int W = 16;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [N*W-1:0] in_words;
  logic           out_valid;
  logic [N*W-1:0] out_words;

  tpose_skew_buffer #(.N(N), .W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_words  (in_words),
    .out_valid (out_valid),
    .out_words (out_words)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  bit mon_on = 0;

  logic [N*W-1:0] exp_q [$];
  int             when_q [$];
  string          tag_q [$];

  task automatic check(input bit ok, input string tag,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen_word(input int mode, input int r, input int k);
    case (mode)
      0:       return W'(r * 256 + k);
      1:       return W'($urandom);
      2:       return W'(r);
      default: return ((r + k) % 2 == 0) ? 16'hFFFF : 16'h8000;
    endcase
  endfunction

  // Driver: sends one block, pushes expected columns, then idles.
  task automatic send_block(input string tag, input int mode,
                            input int gap, input bit junk);
    logic [W-1:0] blk [N][N];
    logic [N*W-1:0] col;
    int base;
    base = 0;
    for (int r = 0; r < N; r++)
      for (int k = 0; k < N; k++)
        blk[r][k] = gen_word(mode, r, k);
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      if (r == 0) base = cyc;
      in_valid = 1'b1;
      for (int k = 0; k < N; k++) in_words[k*W +: W] = blk[r][k];
    end
    for (int k = 0; k < N; k++) begin
      for (int r = 0; r < N; r++) col[r*W +: W] = blk[r][k];
      exp_q.push_back(col);
      when_q.push_back(base + 1 + N + k);
      tag_q.push_back(tag);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_words = junk ? {4{$urandom}} : '0;
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected out_valid", out_words, '0);
        end else begin
          logic [N*W-1:0] e;
          int w;
          string t;
          e = exp_q.pop_front();
          w = when_q.pop_front();
          t = tag_q.pop_front();
          check(cyc == w, {t, " R4 timing"}, (N*W)'(cyc), (N*W)'(w));
          check(out_words == e, {t, " R3 data"}, out_words, e);
        end
      end else if (exp_q.size() != 0 && when_q[0] < cyc) begin
        logic [N*W-1:0] e;
        int w;
        string t;
        e = exp_q.pop_front();
        w = when_q.pop_front();
        t = tag_q.pop_front();
        check(1'b0, {t, " R5 missing column"}, (N*W)'(cyc), (N*W)'(w));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_words = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 reset quiet", (N*W)'(out_valid), '0);
    end
    mon_on = 1;

    send_block("R3 single", 0, 20, 1'b0);
    send_block("R2 row order", 2, 20, 1'b0);
    // R5: continuous stream
    for (int b = 0; b < 4; b++) send_block("R5 stream", 1, 0, 1'b0);
    send_block("R5 stream extreme", 3, 0, 1'b0);
    send_block("R5 stream end", 1, 12, 1'b0);
    // R6: gaps shorter and longer than the drain
    send_block("R6 gap1", 1, 1, 1'b0);
    send_block("R6 gap3", 1, 3, 1'b0);
    send_block("R6 gap7", 1, 7, 1'b0);
    send_block("R6 gap9", 1, 9, 1'b0);
    send_block("R6 gap13", 1, 13, 1'b0);
    // R7: junk on data inputs while in_valid is low
    send_block("R7 junk", 1, 2, 1'b1);
    send_block("R7 junk", 0, 5, 1'b1);
    send_block("R7 junk", 1, 30, 1'b1);

    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R5 all columns seen", (N*W)'(exp_q.size()), '0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R5 idle after drain", (N*W)'(out_valid), '0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule